// File: doc/BRIEF.md
# Tri-Level Input Watchdog Timer

This block watches a processor's heartbeat line and asks for a system reset when the line stops moving. A front end outside the block handles the three-state input and reduces it to two digital signals. `wdi_level` carries the logic level the processor drives. `wdi_float` is high when the line is left undriven. Both signals pass through a synchroniser. Every change of the synchronised level, rising or falling, restarts a cycle counter. When the counter has run for `WD_CYCLES` counting cycles without a change, the block raises `wd_timeout` for exactly one clock. That pulse goes to the reset generator.

The counter is held at zero and does not count in three cases: while the reset generator drives `wd_hold` (its reset output), while the line floats, and while the backup-mode controller drives `wd_disable`. If the processor ties the line to a fixed level and the reset generator stretches each request into a pulse of P cycles, the timeout requests repeat every `WD_CYCLES` + P cycles. The default `WD_CYCLES` gives about 1.6 s at a 200 MHz clock.

Top module: `wdog_tri_timer`

## Requirements
- R1: While `rst_n` is low, `wd_timeout` is low.
- R2: The counter is enabled when `wd_hold`, `wd_disable` and the synchronised float flag are all low. If the counter is enabled at edge n and at every later edge, with no level change, `wd_timeout` is high in the cycle after edge n+WD_CYCLES-1, and not earlier.
- R3: `wd_timeout` is high for a single cycle, and the count restarts from zero in the next cycle. If the counter stays enabled and the level stays fixed, pulses repeat every WD_CYCLES cycles.
- R4: A change of `wdi_level`, in either direction, applied before edge n restarts the count. The next pulse then follows edge n+SYNC_STAGES+WD_CYCLES, and no pulse comes earlier.
- R5: `wd_hold` is sampled at each clock edge. While it is high, the count stays at zero and no pulse is issued. If `wd_hold` goes high for P cycles right after each pulse, the pulses repeat every WD_CYCLES+P cycles.
- R6: While `wdi_float` is high, no pulse is issued. If the line is released before edge n, the next pulse follows edge n+SYNC_STAGES-1+WD_CYCLES.
- R7: While `wd_disable` is high, it holds the counter at zero in the same way as `wd_hold`, and no pulse is issued.
- R8: A level pulse one clock period wide counts as activity. The count restarts from the later of its two edges, so the next pulse follows edge n+SYNC_STAGES+1+WD_CYCLES, where n is the first edge after the pulse begins.
- R9: A level change or a `wd_hold` that reaches the counter at the edge on which the count would expire wins over the expiry. No pulse is issued at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset, synchronous |
| wdi_level | input | 1 | Driven logic level of the heartbeat line (asynchronous) |
| wdi_float | input | 1 | High while the heartbeat line is undriven (asynchronous) |
| wd_hold | input | 1 | System reset currently asserted; holds the counter clear |
| wd_disable | input | 1 | Backup-mode disable; holds the counter clear |
| wd_timeout | output | 1 | One-cycle timeout request to the reset generator |

## Verification
Two functions of the block can land on the same clock edge: the expiry of the count, and a restart of the count, caused either by a level change or by the hold input. The bench provokes both cases. It times a level toggle so that, after the synchroniser delay, the detected edge arrives exactly at the terminal count. In a separate run it raises `wd_hold` for just that one edge. In both cases it checks that no pulse appears at the suppressed edge and that the next pulse comes one full timeout later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Width of a counter that must hold values 0 .. cycles-1.
  function automatic int wdog_cnt_bits(input longint unsigned cycles);
    if (cycles <= 2) return 1;
    return $clog2(cycles);
  endfunction

  // Clock edges from the first enabled edge to the edge that fires.
  function automatic longint unsigned wdog_fire_offset(input longint unsigned cycles);
    return cycles - 1;
  endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/wdog_edge.sv
module wdog_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_s,
  output logic lvl_edge
);

  logic lvl_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl_s;
  end

  assign lvl_edge = lvl_s ^ lvl_prev;

endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter longint unsigned WD_CYCLES = 64,
  localparam int CW = wdog_cnt_bits(WD_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          restart,
  output logic          timeout,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] LAST = CW'(wdog_fire_offset(WD_CYCLES));

  logic at_last;
  logic expire;

  assign at_last = (count == LAST);
  assign expire  = !clear && !restart && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= expire;
      if (clear || restart || at_last) count <= '0;
      else                             count <= count + 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout); // R3
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!timeout && count == '0)); // R5
  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!timeout && count == '0)); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !restart && count != LAST) |=> (count == $past(count) + 1'b1 && !timeout)); // R2
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LAST); // R2

endmodule

// File: rtl/wdog_tri_timer.sv
module wdog_tri_timer
  import wdog_pkg::*;
#(
  parameter longint unsigned WD_CYCLES   = 320_000_000,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi_level,
  input  logic wdi_float,
  input  logic wd_hold,
  input  logic wd_disable,
  output logic wd_timeout
);

  localparam int CW = wdog_cnt_bits(WD_CYCLES);

  logic [1:0]    raw_in;
  logic [1:0]    sync_out;
  logic          lvl_s;
  logic          float_s;
  logic          lvl_edge;
  logic          cnt_clear;
  logic [CW-1:0] cnt_value;

  assign raw_in = {wdi_float, wdi_level};

  wdog_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b10)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .d_sync  (sync_out)
  );

  assign lvl_s   = sync_out[0];
  assign float_s = sync_out[1];

  wdog_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_s    (lvl_s),
    .lvl_edge (lvl_edge)
  );

  assign cnt_clear = wd_hold | wd_disable | float_s;

  wdog_count #(
    .WD_CYCLES (WD_CYCLES)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cnt_clear),
    .restart (lvl_edge),
    .timeout (wd_timeout),
    .count   (cnt_value)
  );

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hold |=> !wd_timeout); // R5
  AST_DISABLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wd_disable |=> !wd_timeout); // R7
  AST_FLOAT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    float_s |=> !wd_timeout); // R6
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !wd_timeout); // R1

endmodule

// File: tb/wdog_tri_timer_test.sv
module wdog_tri_timer_test;

  localparam int W     = 40;
  localparam int SYNC  = 2;
  localparam int PULSE = 6;
  localparam int NONE  = 16'hFFFF;
  localparam int SPAN  = W + 8;

  // {toggle, float, disable, hold, expected first-pulse offset (NONE = no pulse)}
  localparam logic [19:0] VEC [6] = '{
    {4'b0000, 16'(W - 1)},      // R2 plain count
    {4'b1000, 16'(W + SYNC)},   // R4 level change restarts
    {4'b0100, 16'(NONE)},       // R6 floating line
    {4'b0010, 16'(NONE)},       // R7 disable input
    {4'b0001, 16'(NONE)},       // R5 hold kept high
    {4'b1000, 16'(W + SYNC)}    // R4 change in the other direction
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdi_level = 1'b0;
  logic wdi_float = 1'b0;
  logic wd_hold = 1'b1;
  logic wd_disable = 1'b0;
  logic wd_timeout;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_tri_timer #(.WD_CYCLES(W), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .wdi_level(wdi_level), .wdi_float(wdi_float),
    .wd_hold(wd_hold), .wd_disable(wd_disable), .wd_timeout(wd_timeout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Call at a negedge right after driving; base is the next posedge.
  task automatic watch(input int span, output int first, output int second, output int hits);
    int base;
    base = cyc + 1;
    first = NONE; second = NONE; hits = 0;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (wd_timeout) begin
        if (hits == 0) first = cyc - base;
        else if (hits == 1) second = cyc - base;
        hits++;
      end
    end
  endtask

  task automatic preamble();
    @(negedge clk);
    wd_hold = 1'b1; wdi_float = 1'b0; wd_disable = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int f, s, h, t0, guard;
    // R1 reset state
    repeat (5) begin
      @(negedge clk);
      chk("R1 timeout low in reset", int'(wd_timeout), 0);
    end
    rst_n = 1'b1;
    preamble();

    // Vector table
    for (int v = 0; v < 6; v++) begin
      preamble();
      wd_hold    = VEC[v][16];
      wd_disable = VEC[v][17];
      wdi_float  = VEC[v][18];
      if (VEC[v][19]) wdi_level = ~wdi_level;
      watch(SPAN, f, s, h);
      chk($sformatf("vector %0d first pulse offset", v), f, int'(VEC[v][15:0]));
      chk($sformatf("vector %0d pulse count", v), h, (VEC[v][15:0] == 16'hFFFF) ? 0 : 1);
    end

    // R3 free running period and single-cycle pulses
    preamble();
    wd_hold = 1'b0;
    watch(3 * W + 4, f, s, h);
    chk("R3 first pulse", f, W - 1);
    chk("R3 period", s - f, W);
    chk("R3 pulse count", h, 3);

    // R5 periodic requests with a stretched hold
    preamble();
    wd_hold = 1'b0;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!wd_timeout && guard < 4 * W);
    t0 = cyc;
    wd_hold = 1'b1;
    repeat (PULSE) @(negedge clk);
    wd_hold = 1'b0;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!wd_timeout && guard < 4 * W);
    chk("R5 repeat period with hold", cyc - t0, W + PULSE);

    // R9 level change meets terminal count
    preamble();
    wd_hold = 1'b0;
    repeat (W - 3) @(negedge clk);
    wdi_level = ~wdi_level;
    watch(SPAN, f, s, h);
    chk("R9 edge beats expiry", f, W + SYNC);
    chk("R9 edge beats expiry count", h, 1);

    // R9 hold meets terminal count
    preamble();
    wd_hold = 1'b0;
    repeat (W - 1) @(negedge clk);
    wd_hold = 1'b1;
    @(negedge clk);
    chk("R9 hold beats expiry", int'(wd_timeout), 0);
    wd_hold = 1'b0;
    watch(SPAN, f, s, h);
    chk("R9 count resumes after hold", f, W - 1);

    // R8 one-cycle level pulse
    preamble();
    wd_hold = 1'b0;
    wdi_level = ~wdi_level;
    @(negedge clk);
    wdi_level = ~wdi_level;
    watch(SPAN, f, s, h);
    chk("R8 short pulse restarts", f, W + SYNC);

    // R6 release of a floating line
    preamble();
    wdi_float = 1'b1;
    repeat (3) @(negedge clk);
    wd_hold = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 no pulse while floating", int'(wd_timeout), 0);
    wdi_float = 1'b0;
    watch(SPAN, f, s, h);
    chk("R6 pulse after float release", f, W + SYNC - 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule